// File: doc/BRIEF.md
# Four-Port Crossbar Routing Configuration Controller

This block decides which ports of a four-port, 9-bit crossbar are connected. Every port has a 2-bit route code. When a port's code equals its own index, that port is a source. Any other code makes the port a destination, and the code names the port that feeds it. Because a port cannot name itself as a feed, every combination of codes means something, and no input pattern is illegal. Several destinations may name the same source, which broadcasts that source to all of them. The pass switches are modelled as a one-way multiplexer: each port has a 9-bit input, a 9-bit output and an output drive flag.

The route codes reach the crossbar through a storage stage that works in one of two ways. With the transparent control high, the codes act on the crossbar directly, like an open latch. With the transparent control low, the codes are captured on a rising clock edge only while the active-low load control is asserted; otherwise the stored codes are kept. Two things force every path off: a global route enable held low, and an asynchronous active-low power-on reset. The reset also returns the stored codes to "every port a source".

Top module: `xbar_cfg_ctrl`

## Requirements
- R1: The route code of port p sits at `route_sel[2p+1:2p]` (A=0, B=1, C=2, D=3), and the data of port p sits at bits `[9p+8:9p]` of `port_in` and `port_out`. A code equal to p makes port p a source. Any other value k makes port p a destination fed from port k.
- R2: A destination drives (its bit of `port_drive` is 1, and `port_out` carries the input of port k) only when port k is currently a source.
- R3: A source port never drives. Its drive bit is 0.
- R4: A port whose drive bit is 0 puts all zeros on its `port_out` field.
- R5: While `route_en` is low, every drive bit is 0 whatever the other controls do. The storage stage keeps working during this time.
- R6: While `cfg_transparent` is high, the effective codes equal `route_sel` in the same cycle, with no clock edge needed.
- R7: While `cfg_transparent` is low and `load_n` is low, `route_sel` is captured at a rising `clk` edge and takes effect after that edge, not before it.
- R8: While `cfg_transparent` is low and `load_n` is high, the stored codes stay unchanged across clock edges.
- R9: While `cfg_transparent` is high, the store takes `route_sel` at every rising edge. After `cfg_transparent` falls, the codes taken at the last such edge stay in effect.
- R10: A low `rst_n` clears the stored codes to all-source (the code of each port equals its own index) without waiting for a clock edge. While `rst_n` is low, every drive bit is 0, even in transparent mode.
- R11: Several destinations that name the same source are all driven from that source at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock for the stored codes |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| route_en | input | 1 | Global enable; low turns every path off |
| cfg_transparent | input | 1 | High: codes pass straight through; low: stored codes apply |
| load_n | input | 1 | Active-low capture enable used when not transparent |
| route_sel | input | 8 | Four 2-bit route codes, port A in the low bits |
| port_in | input | 36 | Input data of the four ports, 9 bits each |
| port_out | output | 36 | Routed output data of the four ports |
| port_drive | output | 4 | One drive flag per port |

## Verification
The clocked properties on the store assume that `route_sel`, `cfg_transparent` and `load_n` are settled before each rising edge. The bench meets this by changing every input only just after the falling edge. The property that ties the held codes to the last transparent edge expects `route_sel` to stay steady up to that edge. The bench therefore changes the codes and lowers the transparent control together, so the value held is always the one already sampled at the previous edge. Reset is asserted between clock edges to exercise the asynchronous clear, and every property is disabled while reset is low.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
    localparam int unsigned XB_PORTS = 4;
    localparam int unsigned XB_WIDTH = 9;

    typedef enum logic {
        ROLE_SOURCE = 1'b0,
        ROLE_DEST   = 1'b1
    } port_role_e;
endpackage

// File: rtl/xbar_cfg_store.sv
module xbar_cfg_store #(
    parameter int unsigned NPORTS = xbar_pkg::XB_PORTS,
    parameter int unsigned SELW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    parameter int unsigned CFGW   = NPORTS * SELW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_transparent,
    input  logic            load_n,
    input  logic [CFGW-1:0] sel_in,
    output logic [CFGW-1:0] cfg_eff
);
    function automatic logic [CFGW-1:0] identity_codes();
        logic [CFGW-1:0] r;
        r = '0;
        for (int i = 0; i < int'(NPORTS); i++) begin
            r[i*SELW +: SELW] = SELW'(i);
        end
        return r;
    endfunction

    localparam logic [CFGW-1:0] RESET_CODES = identity_codes();

    typedef struct packed {
        logic [CFGW-1:0] codes;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_transparent || !load_n) begin
            st_d.codes = sel_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.codes <= RESET_CODES;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_eff = cfg_transparent ? sel_in : st_q.codes;

    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_transparent && !load_n) |=> (st_q.codes == $past(sel_in)));

    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_transparent && load_n) |=> $stable(st_q.codes));

    p_track_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_transparent |=> (st_q.codes == $past(sel_in)));
endmodule

// File: rtl/xbar_sel_decode.sv
module xbar_sel_decode #(
    parameter int unsigned NPORTS = xbar_pkg::XB_PORTS,
    parameter int unsigned SELW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    parameter int unsigned CFGW   = NPORTS * SELW
) (
    input  logic [CFGW-1:0]   cfg,
    output logic [NPORTS-1:0] is_src,
    output logic [NPORTS-1:0] code_valid
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        logic [SELW-1:0]    code;
        xbar_pkg::port_role_e role;
        assign code          = cfg[p*SELW +: SELW];
        assign role          = (code == SELW'(p)) ? xbar_pkg::ROLE_SOURCE : xbar_pkg::ROLE_DEST;
        assign is_src[p]     = (role == xbar_pkg::ROLE_SOURCE);
        assign code_valid[p] = (int'(code) < int'(NPORTS));
    end
endmodule

// File: rtl/xbar_route_mux.sv
module xbar_route_mux #(
    parameter int unsigned NPORTS = xbar_pkg::XB_PORTS,
    parameter int unsigned WIDTH  = xbar_pkg::XB_WIDTH,
    parameter int unsigned SELW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    parameter int unsigned CFGW   = NPORTS * SELW,
    parameter int unsigned BUSW   = NPORTS * WIDTH
) (
    input  logic              live,
    input  logic [CFGW-1:0]   cfg,
    input  logic [NPORTS-1:0] is_src,
    input  logic [NPORTS-1:0] code_valid,
    input  logic [BUSW-1:0]   port_in,
    output logic [BUSW-1:0]   port_out,
    output logic [NPORTS-1:0] port_drive
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_dst
        logic [SELW-1:0]  feed;
        logic             feed_is_src;
        logic             drive;
        logic [WIDTH-1:0] data;

        assign feed = cfg[p*SELW +: SELW];

        always_comb begin
            feed_is_src = 1'b0;
            data        = '0;
            for (int k = 0; k < int'(NPORTS); k++) begin
                if (feed == SELW'(k)) begin
                    feed_is_src = is_src[k];
                    data        = port_in[k*WIDTH +: WIDTH];
                end
            end
            drive = live && code_valid[p] && !is_src[p] && feed_is_src;
        end

        assign port_drive[p]              = drive;
        assign port_out[p*WIDTH +: WIDTH] = drive ? data : '0;
    end
endmodule

// File: rtl/xbar_cfg_ctrl.sv
module xbar_cfg_ctrl #(
    parameter int unsigned NPORTS = xbar_pkg::XB_PORTS,
    parameter int unsigned WIDTH  = xbar_pkg::XB_WIDTH,
    parameter int unsigned SELW   = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    parameter int unsigned CFGW   = NPORTS * SELW,
    parameter int unsigned BUSW   = NPORTS * WIDTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              route_en,
    input  logic              cfg_transparent,
    input  logic              load_n,
    input  logic [CFGW-1:0]   route_sel,
    input  logic [BUSW-1:0]   port_in,
    output logic [BUSW-1:0]   port_out,
    output logic [NPORTS-1:0] port_drive
);
    logic [CFGW-1:0]   cfg_eff;
    logic [NPORTS-1:0] is_src;
    logic [NPORTS-1:0] code_valid;
    logic              live;

    assign live = route_en && rst_n;

    xbar_cfg_store #(.NPORTS(NPORTS), .SELW(SELW), .CFGW(CFGW)) u_store (
        .clk             (clk),
        .rst_n           (rst_n),
        .cfg_transparent (cfg_transparent),
        .load_n          (load_n),
        .sel_in          (route_sel),
        .cfg_eff         (cfg_eff)
    );

    xbar_sel_decode #(.NPORTS(NPORTS), .SELW(SELW), .CFGW(CFGW)) u_decode (
        .cfg        (cfg_eff),
        .is_src     (is_src),
        .code_valid (code_valid)
    );

    xbar_route_mux #(.NPORTS(NPORTS), .WIDTH(WIDTH), .SELW(SELW), .CFGW(CFGW), .BUSW(BUSW)) u_mux (
        .live       (live),
        .cfg        (cfg_eff),
        .is_src     (is_src),
        .code_valid (code_valid),
        .port_in    (port_in),
        .port_out   (port_out),
        .port_drive (port_drive)
    );

    // R10: every path is off while the power-on reset is held
    always_comb begin
        if (!rst_n) begin
            a_reset_off_r10: assert (port_drive == '0);
        end
    end

    p_gate_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !route_en |-> (port_drive == '0));

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk
        logic [SELW-1:0] feed;
        assign feed = route_sel[p*SELW +: SELW];
        // R3: a port named as feed by a driven destination is itself quiet
        p_src_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_transparent && port_drive[p]) |-> !port_drive[feed]);
        // R4: an undriven port outputs zero
        p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !port_drive[p] |-> (port_out[p*WIDTH +: WIDTH] == '0));
    end
endmodule

// File: tb/tb_xbar_cfg_ctrl.sv
module tb_xbar_cfg_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        route_en = 1'b0;
    logic        cfg_transparent = 1'b0;
    logic        load_n = 1'b1;
    logic [7:0]  route_sel = 8'h00;
    logic [35:0] port_in = '0;
    logic [35:0] port_out;
    logic [3:0]  port_drive;

    int n_checks = 0;
    int n_fail   = 0;
    int m_codes [4];

    always #5 clk = ~clk;

    xbar_cfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .route_en(route_en),
        .cfg_transparent(cfg_transparent), .load_n(load_n),
        .route_sel(route_sel), .port_in(port_in),
        .port_out(port_out), .port_drive(port_drive)
    );

    // reference store: each port's stored feed index
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) m_codes[i] = i;
        end else if (cfg_transparent || !load_n) begin
            for (int i = 0; i < 4; i++) m_codes[i] = int'(route_sel[2*i +: 2]);
        end
    end

    task automatic compare(input string tag);
        int          eff [4];
        logic [3:0]  e_drv;
        logic [35:0] e_out;
        for (int i = 0; i < 4; i++)
            eff[i] = cfg_transparent ? int'(route_sel[2*i +: 2]) : m_codes[i];
        e_drv = '0;
        e_out = '0;
        for (int i = 0; i < 4; i++) begin
            if (rst_n && route_en && eff[i] != i && eff[eff[i]] == eff[i]) begin
                e_drv[i] = 1'b1;
                e_out[9*i +: 9] = port_in[9*eff[i] +: 9];
            end
        end
        n_checks++;
        if (port_drive !== e_drv || port_out !== e_out) begin
            n_fail++;
            $display("FAIL %s: drive=%b out=%h expected drive=%b out=%h",
                     tag, port_drive, port_out, e_drv, e_out);
        end
    endtask

    task automatic step(input logic en, input logic tr, input logic ld_n,
                        input logic [7:0] sel, input string tag);
        @(negedge clk);
        route_en        = en;
        cfg_transparent = tr;
        load_n          = ld_n;
        route_sel       = sel;
        port_in         = {$urandom, $urandom};
        #1;
        compare(tag);
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // R10: reset held, transparent and enabled, still no paths
        step(1'b1, 1'b1, 1'b0, 8'h00, "R10 reset transparent");
        step(1'b1, 1'b1, 1'b0, 8'h55, "R10 reset transparent");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 8'h00, "R10 reset all-source");
        step(1'b1, 1'b0, 1'b1, 8'h1B, "R10 R8 reset held");

        // R6 R1 R2 R3 R4 R11: every code pattern straight through
        for (int c = 0; c < 256; c++)
            step(1'b1, 1'b1, 1'b1, 8'(c), "R6 R1 R2 R3 R4 R11 transparent");

        // R7: clocked load, each pattern visible only after the edge
        for (int c = 0; c < 256; c++)
            step(1'b1, 1'b0, 1'b0, 8'(255 - c), "R7 clocked load");

        // R8: load disabled, codes keep the last loaded value
        step(1'b1, 1'b0, 1'b0, 8'b00_00_00_00, "R7 load broadcast");
        step(1'b1, 1'b0, 1'b1, 8'b11_10_01_00, "R8 hold");
        step(1'b1, 1'b0, 1'b1, 8'b01_00_11_10, "R8 hold");
        step(1'b1, 1'b0, 1'b1, 8'b10_11_00_01, "R8 hold");

        // R11: A source, B C D all fed from A
        step(1'b1, 1'b1, 1'b1, 8'b00_00_00_00, "R11 broadcast from A");
        step(1'b1, 1'b1, 1'b1, 8'b11_11_11_11, "R11 broadcast from D");

        // R9: transparent then falling with new codes on the same cycle
        step(1'b1, 1'b1, 1'b1, 8'b10_10_10_01, "R9 open");
        step(1'b1, 1'b0, 1'b1, 8'b00_00_00_00, "R9 held after fall");
        step(1'b1, 1'b0, 1'b1, 8'b11_11_11_11, "R9 held after fall");

        // R5: enable low blocks all paths, storage still loads
        step(1'b0, 1'b1, 1'b1, 8'b00_00_00_00, "R5 off transparent");
        step(1'b0, 1'b0, 1'b0, 8'b01_01_01_01, "R5 off loading");
        step(1'b0, 1'b0, 1'b1, 8'b00_00_00_00, "R5 off holding");
        step(1'b1, 1'b0, 1'b1, 8'b00_00_00_00, "R5 load during off applies");

        // R10: asynchronous reset mid-cycle clears stored codes
        @(negedge clk);
        #2;
        rst_n = 1'b0;
        #1;
        compare("R10 async clear");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 8'b01_01_01_01, "R10 stored all-source");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule